// File: doc/BRIEF.md
# Debug Register File Controller

This block keeps a processor core's debug state: four breakpoint address registers, one control register that arms and describes the breakpoints, and one status register that records why debug entry happened. Software reaches all six through a single register-move access port. Each access carries a register select, a write flag, write data and the current privilege level. Only privilege level zero may touch the registers. Any other level gets a protection-fault flag, read data of zero, and no change to the registers.

The core also reports events to the block. A task switch strips the task-local breakpoint enables and keeps the global ones. It also raises the task-trap status bit when the incoming task requests a trap. Single-step events, per-slot breakpoint hit flags and an emulator-owns-registers flag set their own status bits. Status bits are sticky: hardware only ever sets them, and only a software write clears them. Address comparison and exception sequencing live elsewhere. The register contents are exported so that those blocks can use them.

Top module: `dbg_regfile`

## Requirements
- R1: The access select decodes as 0 to 3 for address slots 0 to 3, 4 for control and 5 for status. A privileged write updates the chosen register at the next clock edge. A privileged read returns its current contents in the same cycle. Selects 6 and 7 read as zero and writes to them change nothing.
- R2: An access with a nonzero privilege level raises `gp_fault` in the same cycle. Its read data is zero and it leaves every register unchanged.
- R3: The control register is laid out as follows. Bit 2n is slot n's local enable and bit 2n+1 is its global enable. Bit 8 is the local exact-match bit and bit 9 is the global exact-match bit. Bits 16+4n to 19+4n hold slot n's access type (low two bits) and length (high two bits). Bits 10 to 15 always read as zero.
- R4: On a `task_switch` pulse, control bits 0, 2, 4, 6 and 8 are cleared and bits 1, 3, 5, 7, 9 and 16 to 31 are kept. This also applies when a control write happens in the same cycle: the write lands first and the clear is applied on top of it.
- R5: A slot hit flag sets status bit n (bits 0 to 3) at the next edge, whatever the control enables hold.
- R6: A task switch with `new_task_trap` high sets status bit 15. A task switch with it low leaves bit 15 alone.
- R7: A `step_event` sets status bit 14.
- R8: Any access made while `emu_owns` is high sets status bit 13. The privilege level does not matter.
- R9: Status bits are cleared only by a status write. When a status write and a hardware set arrive in the same cycle, the set wins.
- R10: Reset clears all six registers to zero.
- R11: Only status bits 0 to 3 and 13 to 15 can be written. All other status bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register-move access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 32 | Write data |
| cur_cpl | input | 2 | Current privilege level |
| task_switch | input | 1 | Task switch pulse |
| new_task_trap | input | 1 | Trap bit of the incoming task |
| step_event | input | 1 | Single-step trap occurred |
| slot_hit | input | 4 | Per-slot breakpoint condition met |
| emu_owns | input | 1 | Emulator is using the debug registers |
| rd_data | output | 32 | Read data |
| gp_fault | output | 1 | Protection fault on this access |
| addr_q | output | 128 | Address slots, slot n at bits 32n+31:32n |
| ctrl_q | output | 32 | Control register |
| stat_q | output | 32 | Status register |

## Verification
Several properties are checked on every cycle:
- A faulting access leaves the control and address registers unchanged and reads as zero.
- A task switch leaves no local enable standing and keeps the global half intact.
- Status bits never fall without a status write.
- A hit is always recorded.

Other behaviour can only be shown by the bench's scenarios with known values:
- the exact read-back of each select;
- the masking of reserved bits;
- the dependence of the task-trap bit on the incoming trap flag;
- the same-cycle clash between a clearing write and a hit.

// File: rtl/dbg_regfile_pkg.sv
// Shared constants for the debug register file.
// Assumes a 32-bit register width and four breakpoint slots.
package dbg_regfile_pkg;
    localparam int SLOTS    = 4;
    localparam int DW       = 32;
    localparam int SELW     = 3;
    localparam int CPLW     = 2;

    localparam logic [SELW-1:0] SEL_CTRL = 3'd4;
    localparam logic [SELW-1:0] SEL_STAT = 3'd5;

    // Control: enables 0..9 and slot fields 16..31 are storable
    localparam logic [DW-1:0] CTRL_WMASK = 32'hFFFF_03FF;
    // Control bits dropped on a task switch: L0..L3 and local exact-match
    localparam logic [DW-1:0] CTRL_LOCAL = 32'h0000_0155;
    // Status: hit bits 0..3, emulator conflict 13, step 14, task trap 15
    localparam logic [DW-1:0] STAT_WMASK = 32'h0000_E00F;

    localparam int STAT_EMU  = 13;
    localparam int STAT_STEP = 14;
    localparam int STAT_TASK = 15;
endpackage

// File: rtl/dbg_access_gate.sv
// Decodes a register-move access and checks its privilege level.
// Assumes at most one access per cycle; only level zero is privileged.
module dbg_access_gate
    import dbg_regfile_pkg::*;
(
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [SELW-1:0] acc_sel,
    input  logic [CPLW-1:0] cur_cpl,
    output logic            fault,
    output logic            allowed,
    output logic [SLOTS-1:0] wr_addr,
    output logic            wr_ctrl,
    output logic            wr_stat
);
    // Privilege check and one-hot write strobes
    always_comb begin
        fault   = acc_valid && (cur_cpl != '0);
        allowed = acc_valid && (cur_cpl == '0);
        wr_ctrl = allowed && acc_write && (acc_sel == SEL_CTRL);
        wr_stat = allowed && acc_write && (acc_sel == SEL_STAT);
        for (int i = 0; i < SLOTS; i++)
            wr_addr[i] = allowed && acc_write && (acc_sel == SELW'(i));
    end
endmodule

// File: rtl/dbg_addr_bank.sv
// Holds the breakpoint address slots, one register per slot.
// Assumes the write strobes are at most one-hot and already privilege-checked.
module dbg_addr_bank
    import dbg_regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SLOTS-1:0]    wr_en,
    input  logic [DW-1:0]       wdata,
    output logic [SLOTS*DW-1:0] addr_q
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DW-1:0] q;
        // Load this slot on its own write strobe
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= '0;
            else if (wr_en[g]) q <= wdata;
        end
        assign addr_q[g*DW +: DW] = q;
    end
endmodule

// File: rtl/dbg_ctrl_reg.sv
// Control register: breakpoint enables, exact-match bits and slot fields.
// Assumes task_switch is a single-cycle pulse; the write applies before the local clear.
module dbg_ctrl_reg
    import dbg_regfile_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          task_switch,
    output logic [DW-1:0] ctrl_q
);
    logic [DW-1:0] nxt;

    // Pick the written value, then strip local bits on a switch
    always_comb begin
        nxt = wr_en ? (wdata & CTRL_WMASK) : ctrl_q;
        if (task_switch) nxt = nxt & ~CTRL_LOCAL;
    end

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= nxt;
    end

    AST_LOCAL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> (ctrl_q & CTRL_LOCAL) == '0); // R4
    AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !wr_en) |=> (ctrl_q & ~CTRL_LOCAL) == ($past(ctrl_q) & ~CTRL_LOCAL)); // R4
    AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctrl_q & ~CTRL_WMASK) == '0); // R3
endmodule

// File: rtl/dbg_status_reg.sv
// Sticky status register: hardware only sets bits, software writes clear them.
// Assumes a hardware set and a software write in the same cycle resolve in favour of the set.
module dbg_status_reg
    import dbg_regfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    input  logic [SLOTS-1:0] hit,
    input  logic             set_emu,
    input  logic             set_step,
    input  logic             set_task,
    output logic [DW-1:0]    stat_q
);
    logic [DW-1:0] base;
    logic [DW-1:0] sets;

    // Software base value and the hardware set vector
    always_comb begin
        base = wr_en ? (wdata & STAT_WMASK) : stat_q;
        sets = '0;
        sets[SLOTS-1:0] = hit;
        sets[STAT_EMU]  = set_emu;
        sets[STAT_STEP] = set_step;
        sets[STAT_TASK] = set_task;
    end

    // Register update: sets always win
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= base | sets;
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R9
    AST_HIT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> (stat_q[SLOTS-1:0] & $past(hit)) == $past(hit)); // R5
    AST_TASK_TRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_task |=> stat_q[STAT_TASK]); // R6
endmodule

// File: rtl/dbg_regfile.sv
// Debug register file top: access gate, address bank, control and status registers.
// Assumes reads are combinational on the current contents and events are single-cycle pulses.
module dbg_regfile
    import dbg_regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [2:0]          acc_sel,
    input  logic [31:0]         acc_wdata,
    input  logic [1:0]          cur_cpl,
    input  logic                task_switch,
    input  logic                new_task_trap,
    input  logic                step_event,
    input  logic [3:0]          slot_hit,
    input  logic                emu_owns,
    output logic [31:0]         rd_data,
    output logic                gp_fault,
    output logic [127:0]        addr_q,
    output logic [31:0]         ctrl_q,
    output logic [31:0]         stat_q
);
    logic             allowed;
    logic [SLOTS-1:0] wr_addr;
    logic             wr_ctrl;
    logic             wr_stat;

    dbg_access_gate u_gate (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_sel   (acc_sel),
        .cur_cpl   (cur_cpl),
        .fault     (gp_fault),
        .allowed   (allowed),
        .wr_addr   (wr_addr),
        .wr_ctrl   (wr_ctrl),
        .wr_stat   (wr_stat)
    );

    dbg_addr_bank u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_addr),
        .wdata  (acc_wdata),
        .addr_q (addr_q)
    );

    dbg_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_ctrl),
        .wdata       (acc_wdata),
        .task_switch (task_switch),
        .ctrl_q      (ctrl_q)
    );

    dbg_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_stat),
        .wdata    (acc_wdata),
        .hit      (slot_hit),
        .set_emu  (acc_valid && emu_owns),
        .set_step (step_event),
        .set_task (task_switch && new_task_trap),
        .stat_q   (stat_q)
    );

    // Read multiplexer: zero unless a privileged access selects a register
    always_comb begin
        rd_data = '0;
        if (allowed) begin
            if (acc_sel < SELW'(SLOTS))  rd_data = addr_q[acc_sel[1:0]*DW +: DW];
            else if (acc_sel == SEL_CTRL) rd_data = ctrl_q;
            else if (acc_sel == SEL_STAT) rd_data = stat_q;
        end
    end

    AST_FAULT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_fault && !task_switch) |=> $stable(ctrl_q) && $stable(addr_q)); // R2
    AST_FAULT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> rd_data == '0); // R2
    AST_EMU_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && emu_owns) |=> stat_q[STAT_EMU]); // R8
endmodule

// File: tb/dbg_regfile_test.sv
module dbg_regfile_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0, acc_write = 1'b0;
    logic [2:0]   acc_sel = '0;
    logic [31:0]  acc_wdata = '0;
    logic [1:0]   cur_cpl = '0;
    logic         task_switch = 1'b0, new_task_trap = 1'b0, step_event = 1'b0;
    logic [3:0]   slot_hit = '0;
    logic         emu_owns = 1'b0;
    logic [31:0]  rd_data;
    logic         gp_fault;
    logic [127:0] addr_q;
    logic [31:0]  ctrl_q, stat_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    dbg_regfile uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change 1 time unit after the edge
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; cur_cpl = 0; task_switch = 0;
        new_task_trap = 0; step_event = 0; slot_hit = '0; emu_owns = 0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input logic [1:0] cpl);
        acc_valid = 1; acc_write = 1; acc_sel = sel; acc_wdata = d; cur_cpl = cpl;
        tick(); idle();
    endtask

    // Combinational read, checked in the same cycle
    task automatic rd_expect(input string req, input logic [2:0] sel, input logic [31:0] exp);
        acc_valid = 1; acc_write = 0; acc_sel = sel; cur_cpl = 0; #1;
        check(req, rd_data, exp);
        idle();
    endtask

    task automatic t_reset();
        check("R10 addr", addr_q, '0);
        check("R10 ctrl", ctrl_q, '0);
        check("R10 stat", stat_q, '0);
    endtask

    task automatic t_addr_rw();
        for (int i = 0; i < 4; i++) wr(3'(i), 32'hA000_0000 + 32'(i*16 + 1), 0);
        for (int i = 0; i < 4; i++) rd_expect("R1 addr read", 3'(i), 32'hA000_0000 + 32'(i*16 + 1));
    endtask

    task automatic t_masks();
        wr(3'd4, 32'hFFFF_FFFF, 0);
        rd_expect("R3 ctrl reserved", 3'd4, 32'hFFFF_03FF);
        wr(3'd5, 32'hFFFF_FFFF, 0);
        rd_expect("R11 stat mask", 3'd5, 32'h0000_E00F);
        wr(3'd5, 32'h0, 0);
        check("R9 sw clear", stat_q, 32'h0);
    endtask

    task automatic t_fault();
        acc_valid = 1; acc_write = 1; acc_sel = 0; acc_wdata = 32'h1234_5678; cur_cpl = 3; #1;
        check("R2 fault flag", gp_fault, 1);
        check("R2 fault rdata", rd_data, 0);
        tick(); idle();
        check("R2 addr unchanged", addr_q[31:0], 32'hA000_0001);
        acc_valid = 1; acc_write = 0; acc_sel = 4; cur_cpl = 1; #1;
        check("R2 read fault rdata", rd_data, 0);
        idle();
        wr(3'd4, 32'h0, 2);
        check("R2 ctrl unchanged", ctrl_q, 32'hFFFF_03FF);
    endtask

    task automatic t_task_switch();
        wr(3'd4, 32'h00F3_03FF, 0);
        task_switch = 1; new_task_trap = 0; tick(); idle();
        check("R4 local cleared", ctrl_q, 32'h00F3_02AA);
        check("R6 no trap", stat_q[15], 0);
        task_switch = 1; new_task_trap = 1; tick(); idle();
        check("R6 trap set", stat_q[15], 1);
        // write and switch in the same cycle
        acc_valid = 1; acc_write = 1; acc_sel = 4; acc_wdata = 32'h0000_0155; task_switch = 1;
        tick(); idle();
        check("R4 write then clear", ctrl_q, 32'h0);
        wr(3'd5, 32'h0, 0);
    endtask

    task automatic t_hits();
        slot_hit = 4'b1010; tick(); idle();
        check("R5 hits without enable", stat_q, 32'h0000_000A);
        tick();
        check("R9 sticky", stat_q, 32'h0000_000A);
        step_event = 1; tick(); idle();
        check("R7 step", stat_q, 32'h0000_400A);
    endtask

    task automatic t_emu();
        acc_valid = 1; acc_write = 0; acc_sel = 0; cur_cpl = 3; emu_owns = 1;
        tick(); idle();
        check("R8 emu conflict", stat_q[13], 1);
    endtask

    task automatic t_clash();
        acc_valid = 1; acc_write = 1; acc_sel = 5; acc_wdata = 0; slot_hit = 4'b0001;
        tick(); idle();
        check("R9 set wins", stat_q, 32'h0000_0001);
    endtask

    task automatic t_unused_sel();
        logic [127:0] a;
        logic [31:0] c, s;
        a = addr_q; c = ctrl_q; s = stat_q;
        wr(3'd6, 32'hFFFF_FFFF, 0);
        wr(3'd7, 32'hFFFF_FFFF, 0);
        check("R1 unused no write addr", addr_q, a);
        check("R1 unused no write ctrl", {ctrl_q, stat_q}, {c, s});
        rd_expect("R1 unused reads zero", 3'd6, 32'h0);
    endtask

    initial begin
        idle();
        repeat (2) tick();
        rst_n = 1; tick();
        t_reset();
        t_addr_rw();
        t_masks();
        t_fault();
        t_task_switch();
        t_hits();
        t_emu();
        t_clash();
        t_unused_sel();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule